// File: doc/BRIEF.md
# DRAM circular audio delay controller

This block keeps a circular delay line of 10-bit audio words in an external 1-bit-wide DRAM whose address is multiplexed into row and column halves. Each time a sample tick arrives it services one slot of the ring. For each of the ten bit positions of that slot it reads the stored bit and then writes the matching bit of the new input word back to the same cell. When the slot is done it presents the old word, which is the delayed sample, and moves the ring pointer on by one slot.

Two memory sizes are supported through a single select input. One is 64K cells with eight row and eight column lines. The other is 256K cells, which also uses the ninth address line. A delay-length input, counted in samples, sets how many slots the ring uses. It is clamped to what the selected memory can hold. The controller drives the address bus and the active-low row, column and write strobes. It drives the shared data line only during its write phases. Analog conversion and clock generation are outside the block. The clock must run at least 90 times faster than the sample rate, because one slot takes 90 cycles.

Top module: `dram_delay_ctrl`

## Requirements
- R1: A synchronous reset forces the row, column and write strobes high and releases the data line. It clears `sampleOut` and `sampleValid`, and returns the ring pointer to slot 0, so the first slot after reset starts at cell address 0.
- R2: A `sampleTick` seen while no slot is in progress starts a slot and captures `sampleIn`. A tick seen while a slot is in progress has no effect: there is no second result and no extra pointer advance.
- R3: A slot is ten bit operations, each a read cycle followed by a write cycle at the same cell, and it takes 9 clocks per bit. `sampleValid` is a one-cycle pulse that rises exactly 90 clock edges after the edge that sampled the tick. The column strobe is low only while the row strobe is low.
- R4: The row address is on the bus in the cycle before the row strobe falls, and the column address is on the bus in the cycle before each column strobe fall. Each stays unchanged across that fall.
- R5: The controller drives the data line only while the write strobe is low. Bit i of the input word (bit 0 = LSB) is written to cell address slotBase+i, where slotBase = 10 × slot index.
- R6: The bit read from cell slotBase+i becomes bit i of `sampleOut`. `sampleOut` changes only in the cycle where `sampleValid` is high, and it holds its value between pulses.
- R7: With effective length N, the pointer advances by one slot per completed slot and wraps to slot 0 after slot N−1. If N shrinks below the current slot index, the next advance wraps to 0. Once the ring has filled, each output equals the input from N samples earlier.
- R8: `sizeSel` = 1 selects 64K mode: address line 8 stays low and at most 6553 slots are used. `sizeSel` = 0 selects 256K mode: all nine lines are used and at most 26214 slots. `delayLen` above the limit is clamped to the limit.
- R9: The row takes the low-order cell address bits and the column takes the high-order bits. In 64K mode row = addr[7:0] and column = addr[15:8]. In 256K mode row = addr[8:0] and column = addr[17:9]. Steady advance therefore cycles through the rows, so no separate refresh is needed.
- R10: `delayLen` = 0 is treated as a length of one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleTick | input | 1 | One-cycle request to service the next slot |
| sampleIn | input | 10 | New audio word to store |
| sizeSel | input | 1 | 1 = 64K memory, 0 = 256K memory |
| delayLen | input | 15 | Ring length in samples |
| sampleOut | output | 10 | Delayed audio word |
| sampleValid | output | 1 | One-cycle pulse when `sampleOut` is updated |
| dramAddr | output | 9 | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write strobe, active low |
| dramDq | inout | 1 | Single-bit memory data line |

## Verification
Two events can land in the same cycle: the result pulse that ends one slot, and the tick that begins the next. The bench raises the tick at the falling edge where it first sees `sampleValid`, so the controller samples the tick while the pulse is still high. It then judges three things: the new slot must be accepted, `sampleOut` must keep the just-presented word for the whole following slot, and the next word must arrive exactly 90 edges later with the correct delayed value.

// File: rtl/dly_pkg.sv
package dly_pkg;

  // Phases of one bit operation: read cycle, then write cycle, same cell.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ROW,
    PH_RAS,
    PH_COL,
    PH_RD,
    PH_RDEND,
    PH_WE,
    PH_WR,
    PH_WREND,
    PH_PRE
  } phase_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic start;    // latch new word, restart bit index
    logic useCol;   // put column half on the address bus
    logic capture;  // shift the data line into the read register
    logic driveDq;  // enable the data line driver
    logic nextBit;  // step to the next bit of the slot
    logic finish;   // present result and advance the ring pointer
  } dlyStrobe_t;

endpackage

// File: rtl/dly_control.sv
module dly_control
  import dly_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sampleTick,
  input  logic       lastBit,
  output dlyStrobe_t strb,
  output logic       rasN,
  output logic       casN,
  output logic       weN
);

  phase_t phase;
  phase_t phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (sampleTick) phaseNext = PH_ROW;
      PH_ROW:   phaseNext = PH_RAS;
      PH_RAS:   phaseNext = PH_COL;
      PH_COL:   phaseNext = PH_RD;
      PH_RD:    phaseNext = PH_RDEND;
      PH_RDEND: phaseNext = PH_WE;
      PH_WE:    phaseNext = PH_WR;
      PH_WR:    phaseNext = PH_WREND;
      PH_WREND: phaseNext = PH_PRE;
      PH_PRE:   phaseNext = lastBit ? PH_IDLE : PH_ROW;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  logic rowOpen;
  assign rowOpen = (phase == PH_RAS) || (phase == PH_COL) || (phase == PH_RD) ||
                   (phase == PH_RDEND) || (phase == PH_WE) || (phase == PH_WR) ||
                   (phase == PH_WREND);

  always_comb begin
    rasN         = ~rowOpen;
    casN         = ~((phase == PH_RD) || (phase == PH_WR));
    weN          = ~((phase == PH_WE) || (phase == PH_WR) || (phase == PH_WREND));
    strb.start   = (phase == PH_IDLE) && sampleTick;
    strb.useCol  = rowOpen && (phase != PH_RAS);
    strb.capture = (phase == PH_RD);
    strb.driveDq = (phase == PH_WE) || (phase == PH_WR) || (phase == PH_WREND);
    strb.nextBit = (phase == PH_PRE) && !lastBit;
    strb.finish  = (phase == PH_PRE) && lastBit;
  end

endmodule

// File: rtl/dly_datapath.sv
module dly_datapath
  import dly_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int ADDR_LINES = 9,
  parameter int DLY_W      = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dlyStrobe_t            strb,
  input  logic [SAMPLE_W-1:0]   sampleIn,
  input  logic                  sizeSel,
  input  logic [DLY_W-1:0]      delayLen,
  input  logic                  dqIn,
  output logic                  dqOut,
  output logic                  lastBit,
  output logic [ADDR_LINES-1:0] dramAddr,
  output logic [SAMPLE_W-1:0]   sampleOut,
  output logic                  sampleValid
);

  localparam int BIT_W     = 2 * ADDR_LINES;
  localparam int NARROW    = ADDR_LINES - 1;
  localparam int CAP_BIG   = 1 << BIT_W;
  localparam int CAP_SMALL = 1 << (2 * NARROW);
  localparam int MAX_BIG   = CAP_BIG / SAMPLE_W;
  localparam int MAX_SMALL = CAP_SMALL / SAMPLE_W;
  localparam int IDX_W     = $clog2(SAMPLE_W);

  logic [DLY_W-1:0]    slotIdx;
  logic [BIT_W-1:0]    slotBase;
  logic [IDX_W-1:0]    bitIdx;
  logic [SAMPLE_W-1:0] wrSample;
  logic [SAMPLE_W-1:0] rdShift;

  // Effective ring length: zero means one, and never beyond capacity.
  logic [DLY_W-1:0] limit;
  logic [DLY_W-1:0] effLen;
  always_comb begin
    limit = sizeSel ? DLY_W'(MAX_SMALL) : DLY_W'(MAX_BIG);
    if (delayLen == '0)        effLen = DLY_W'(1);
    else if (delayLen > limit) effLen = limit;
    else                       effLen = delayLen;
  end

  // Pointer advance with wrap, also wrapping when the length shrinks.
  logic [DLY_W:0]   incIdx;
  logic [DLY_W-1:0] nextIdx;
  logic [BIT_W-1:0] nextBase;
  always_comb begin
    incIdx   = {1'b0, slotIdx} + 1'b1;
    nextIdx  = (incIdx >= {1'b0, effLen}) ? '0 : incIdx[DLY_W-1:0];
    nextBase = BIT_W'(nextIdx) * BIT_W'(SAMPLE_W);
  end

  // Cell address and its row/column split; low bits go to the row.
  logic [BIT_W-1:0]      bitAddr;
  logic [ADDR_LINES-1:0] rowAddr;
  logic [ADDR_LINES-1:0] colAddr;
  always_comb begin
    bitAddr = slotBase + BIT_W'(bitIdx);
    if (sizeSel) begin
      rowAddr = {1'b0, bitAddr[NARROW-1:0]};
      colAddr = {1'b0, bitAddr[2*NARROW-1:NARROW]};
    end else begin
      rowAddr = bitAddr[ADDR_LINES-1:0];
      colAddr = bitAddr[BIT_W-1:ADDR_LINES];
    end
    dramAddr = strb.useCol ? colAddr : rowAddr;
  end

  assign lastBit = (bitIdx == IDX_W'(SAMPLE_W - 1));
  assign dqOut   = wrSample[bitIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      slotIdx     <= '0;
      slotBase    <= '0;
      bitIdx      <= '0;
      wrSample    <= '0;
      rdShift     <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strb.finish;
      if (strb.start) begin
        wrSample <= sampleIn;
        bitIdx   <= '0;
      end
      if (strb.capture) rdShift <= {dqIn, rdShift[SAMPLE_W-1:1]};
      if (strb.nextBit) bitIdx <= bitIdx + 1'b1;
      if (strb.finish) begin
        sampleOut <= rdShift;
        slotIdx   <= nextIdx;
        slotBase  <= nextBase;
        bitIdx    <= '0;
      end
    end
  end

endmodule

// File: rtl/dram_delay_ctrl.sv
module dram_delay_ctrl
  import dly_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int ADDR_LINES = 9,
  parameter int DLY_W      = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sampleTick,
  input  logic [SAMPLE_W-1:0]   sampleIn,
  input  logic                  sizeSel,
  input  logic [DLY_W-1:0]      delayLen,
  output logic [SAMPLE_W-1:0]   sampleOut,
  output logic                  sampleValid,
  output logic [ADDR_LINES-1:0] dramAddr,
  output logic                  dramRasN,
  output logic                  dramCasN,
  output logic                  dramWeN,
  inout  wire                   dramDq
);

  dlyStrobe_t strb;
  logic       lastBit;
  logic       dqOut;
  logic       dqOe;
  logic       dqIn;

  assign dqOe   = strb.driveDq;
  assign dramDq = dqOe ? dqOut : 1'bz;
  assign dqIn   = dramDq;

  dly_control i_control (
    .clk        (clk),
    .rst        (rst),
    .sampleTick (sampleTick),
    .lastBit    (lastBit),
    .strb       (strb),
    .rasN       (dramRasN),
    .casN       (dramCasN),
    .weN        (dramWeN)
  );

  dly_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .ADDR_LINES (ADDR_LINES),
    .DLY_W      (DLY_W)
  ) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .sampleIn    (sampleIn),
    .sizeSel     (sizeSel),
    .delayLen    (delayLen),
    .dqIn        (dqIn),
    .dqOut       (dqOut),
    .lastBit     (lastBit),
    .dramAddr    (dramAddr),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

endmodule

// File: rtl/dly_checker.sv
module dly_checker #(
  parameter int SAMPLE_W   = 10,
  parameter int ADDR_LINES = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sizeSel,
  input logic                  sampleValid,
  input logic [SAMPLE_W-1:0]   sampleOut,
  input logic [ADDR_LINES-1:0] dramAddr,
  input logic                  dramRasN,
  input logic                  dramCasN,
  input logic                  dramWeN,
  input logic                  dqOe
);

  p_rst_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dramRasN && dramCasN && dramWeN && !sampleValid && !dqOe));

  p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (rst)
    !dramCasN |-> !dramRasN);

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  p_row_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dramRasN) |-> $stable(dramAddr));

  p_col_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dramCasN) |-> $stable(dramAddr));

  p_drive_we_r5: assert property (@(posedge clk) disable iff (rst)
    dqOe |-> !dramWeN);

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> $stable(sampleOut));

  p_top_line_low_r8: assert property (@(posedge clk) disable iff (rst)
    sizeSel |-> !dramAddr[ADDR_LINES-1]);

endmodule

bind dram_delay_ctrl dly_checker #(
  .SAMPLE_W   (SAMPLE_W),
  .ADDR_LINES (ADDR_LINES)
) u_dlyChecker (
  .clk         (clk),
  .rst         (rst),
  .sizeSel     (sizeSel),
  .sampleValid (sampleValid),
  .sampleOut   (sampleOut),
  .dramAddr    (dramAddr),
  .dramRasN    (dramRasN),
  .dramCasN    (dramCasN),
  .dramWeN     (dramWeN),
  .dqOe        (dqOe)
);

// File: tb/test_dram_delay_ctrl.sv
`timescale 1ns/1ps
module test_dram_delay_ctrl;

  localparam int SLOT_CYCLES = 10 * 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleTick = 1'b0;
  logic [9:0]  sampleIn = '0;
  logic        sizeSel = 1'b1;
  logic [14:0] delayLen = 15'd3;
  logic [9:0]  sampleOut;
  logic        sampleValid;
  logic [8:0]  dramAddr;
  logic        dramRasN, dramCasN, dramWeN;
  wire         dramDq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dram_delay_ctrl i_dram_delay_ctrl (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .sampleIn(sampleIn),
    .sizeSel(sizeSel), .delayLen(delayLen), .sampleOut(sampleOut),
    .sampleValid(sampleValid), .dramAddr(dramAddr), .dramRasN(dramRasN),
    .dramCasN(dramCasN), .dramWeN(dramWeN), .dramDq(dramDq)
  );

  // Memory model: 1-bit cells, row latched on row strobe fall, column on column strobe fall.
  bit         mem [int];
  logic [8:0] rowLatch, colLatch, firstRow, firstCol;
  logic       rdBit = 1'b0;
  logic       armFirst = 1'b0;
  logic       a8Bad = 1'b0;
  int         cellAddr;

  assign dramDq = (!dramCasN && dramWeN) ? rdBit : 1'bz;

  always @(negedge dramRasN) begin
    rowLatch = dramAddr;
    if (armFirst) firstRow = dramAddr;
  end

  always @(negedge dramCasN) begin
    colLatch = dramAddr;
    cellAddr = sizeSel ? int'({colLatch[7:0], rowLatch[7:0]}) : int'({colLatch, rowLatch});
    if (armFirst) begin
      firstCol = dramAddr;
      armFirst = 1'b0;
    end
    if (dramWeN) rdBit = mem.exists(cellAddr) ? mem[cellAddr] : 1'b0;
    else         mem[cellAddr] = dramDq;
  end

  always @(negedge clk) if (!rst && sizeSel && dramAddr[8]) a8Bad = 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseTick(input logic [9:0] v);
    sampleIn   = v;
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic waitValid(output int lat);
    lat = 0;
    while (!sampleValid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic doSample(input logic [9:0] v, output int lat);
    @(negedge clk);
    pulseTick(v);
    waitValid(lat);
  endtask

  function automatic logic [9:0] slotWord(input int base);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[i] = mem.exists(base + i) ? mem[base + i] : 1'b0;
    return w;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // {input word, expected delayed word}; ring length 3, 64K mode.
  localparam logic [19:0] VECTORS [8] = '{
    {10'h155, 10'h000}, {10'h2AA, 10'h000}, {10'h3FF, 10'h000}, {10'h001, 10'h155},
    {10'h200, 10'h2AA}, {10'h0F0, 10'h3FF}, {10'h30C, 10'h001}, {10'h123, 10'h200}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat;
    int vcount;
    int holdBad;
    logic [9:0] seen;

    repeat (3) @(negedge clk);
    check("R1 rasN in reset", dramRasN, 1'b1);
    check("R1 casN in reset", dramCasN, 1'b1);
    check("R1 weN in reset", dramWeN, 1'b1);
    check("R1 out in reset", {sampleValid, sampleOut}, 11'h0);
    rst = 1'b0;

    // Vector table: R7 delay of 3, R3 latency, R1 first slot at address 0
    for (int k = 0; k < 8; k++) begin
      if (k == 0) armFirst = 1'b1;
      doSample(VECTORS[k][19:10], lat);
      check("R7 delayed word", sampleOut, VECTORS[k][9:0]);
      check("R3 latency", lat, SLOT_CYCLES);
      if (k == 0) begin
        check("R1 first row", firstRow, 9'h000);
        check("R1 first col", firstCol, 9'h000);
        @(negedge clk);
        check("R3 one-cycle pulse", sampleValid, 1'b0);
      end
    end
    check("R5 bit order of slot 0", slotWord(0), 10'h30C);
    check("R5 bit order of slot 1", slotWord(10), 10'h123);

    // R2: a tick during a slot is ignored
    @(negedge clk);
    pulseTick(10'h0AA);
    repeat (19) @(negedge clk);
    pulseTick(10'h111);
    vcount = 0;
    seen = '0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (sampleValid) begin
        vcount++;
        seen = sampleOut;
      end
    end
    check("R2 single result", vcount, 1);
    check("R2 result of slot 2", seen, 10'h0F0);
    check("R2 stored word unchanged by ignored tick", slotWord(20), 10'h0AA);
    armFirst = 1'b1;
    doSample(10'h2C3, lat);
    check("R2 pointer advanced once", {firstRow, firstCol}, 18'h0);
    check("R7 wrap word", sampleOut, 10'h30C);

    // R10: zero length behaves as one
    delayLen = 15'd0;
    doSample(10'h05A, lat);
    check("R10 slot 1 content", sampleOut, 10'h123);
    doSample(10'h3A5, lat);
    check("R10 slot 0 content", sampleOut, 10'h2C3);
    doSample(10'h0C3, lat);
    check("R10 one-sample delay", sampleOut, 10'h3A5);
    doSample(10'h2F0, lat);
    check("R10 one-sample delay again", sampleOut, 10'h0C3);

    // R7: shrinking length below the pointer wraps at the next advance
    delayLen = 15'd5;
    doSample(10'h011, lat);
    doSample(10'h022, lat);
    doSample(10'h033, lat);
    delayLen = 15'd2;
    doSample(10'h044, lat);
    check("R7 unused slot 3", sampleOut, 10'h000);
    armFirst = 1'b1;
    doSample(10'h055, lat);
    check("R7 shrink wraps to slot 0", {firstRow, firstCol}, 18'h0);
    check("R7 slot 0 word", sampleOut, 10'h011);
    doSample(10'h066, lat);
    check("R7 slot 1 word", sampleOut, 10'h022);
    doSample(10'h077, lat);
    check("R7 length 2 delay", sampleOut, 10'h055);

    // Same cycle: tick while the result pulse is high (R6, R3)
    delayLen = 15'd1;
    doSample(10'h000, lat);
    doSample(10'h111, lat);
    doSample(10'h155, lat);
    check("R6 presented word", sampleOut, 10'h111);
    pulseTick(10'h2DB);
    holdBad = 0;
    lat = 0;
    while (!sampleValid && lat < 400) begin
      if (sampleOut !== 10'h111) holdBad++;
      @(negedge clk);
      lat++;
    end
    check("R6 output held through next slot", holdBad, 0);
    check("R3 latency of back-to-back slot", lat, SLOT_CYCLES);
    check("R6 next word", sampleOut, 10'h155);

    // R1: reset in the middle of a slot
    @(negedge clk);
    pulseTick(10'h3FF);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 strobes idle after mid-slot reset", {dramRasN, dramCasN, dramWeN}, 3'b111);
    check("R1 line released", (dramDq === 1'bz), 1'b1);
    check("R1 output cleared", {sampleValid, sampleOut}, 11'h0);
    rst = 1'b0;

    // R9, R8: address split in 64K mode, slot 30 -> cell 300 = 0x12C
    sizeSel  = 1'b1;
    delayLen = 15'd40;
    doReset();
    a8Bad = 1'b0;
    for (int k = 0; k < 30; k++) doSample(10'(k), lat);
    armFirst = 1'b1;
    doSample(10'h1E, lat);
    check("R9 64K row low bits", firstRow, 9'h02C);
    check("R9 64K column high bits", firstCol, 9'h001);
    check("R8 line 8 low in 64K mode", a8Bad, 1'b0);

    // R9, R8: 256K mode uses all nine lines
    sizeSel = 1'b0;
    doReset();
    for (int k = 0; k < 30; k++) doSample(10'(k), lat);
    armFirst = 1'b1;
    doSample(10'h1E, lat);
    check("R9 256K row low bits", firstRow, 9'h12C);
    check("R8 256K column", firstCol, 9'h000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule